// File: doc/BRIEF.md
# Staged-Latch Configurable I/O Port

This block is an eight-pin general-purpose I/O port. Each pin has its own mode: input, output, bidirectional, or alternate-function output. The mode comes from three per-pin configuration registers on a small register bus. The block does not own the pads. It produces a drive value, an output enable, an open-drain indication and a weak pull-up enable for each pin, and it receives the pad levels back.

Data moves between the bus and the pins only at instruction boundaries. A bus write to the data register fills a master latch. The pins follow a slave latch, and the slave latch copies the master only when the core pulses the end-of-instruction strobe. In the same way, the pad levels are captured into an input latch only on the start-of-instruction strobe. A read of the data register returns that input latch, so software always sees a snapshot taken at a known point. The slave latch follows the master in every mode, so a pin switched from input to a driving mode shows the value already stored.

Top module: `gpio_stage_port`

## Requirements
- R1: After reset, every pin is bidirectional (all three configuration registers read 8'h00) with pull-up enabled. The master and slave latches hold 8'hFF, so all pads are released (output enable 0). The input latch reads 8'h00.
- R2: Register addresses are: 0 for data, 1 for mode-low bits, 2 for mode-high bits, 3 for the drive-select bits. Per pin, {mode-high, mode-low} selects 00 bidirectional, 01 output, 10 input, 11 alternate-function output. Writes to addresses 1 to 3 take effect on the next clock and read back unchanged.
- R3: A write to address 0 changes only the master latch; the pins do not change. On a clock with instr_end high, the slave latch takes the master value held before that clock edge. A write in the same cycle reaches the pins only at a later instr_end.
- R4: A read of address 0 returns the input latch. The input latch loads pin_in on a clock with instr_start high and otherwise holds. Pad changes without the strobe are invisible to reads.
- R5: In input mode, output enable, open-drain and pull-up are all 0 for that pin. The slave latch still follows the master on instr_end. Switching the pin to output shows the stored value from the next cycle on.
- R6: In bidirectional mode, a slave bit of 0 drives the pad low (enable 1, data 0). A slave bit of 1 releases it. Open-drain reads 1 and pull-up reads 1.
- R7: In output mode with drive-select 0 (push-pull), the pad is enabled and driven with the slave bit. With drive-select 1 (open-drain), the pad behaves as in R6 but without pull-up.
- R8: In alternate-function mode, the pad takes its value combinationally from af_out instead of the slave latch, with the same push-pull or open-drain rule as R7 and no pull-up.
- R9: Pull-up enable is high only for pins in bidirectional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on bus_addr) |
| instr_start | input | 1 | Start-of-instruction strobe, samples pads |
| instr_end | input | 1 | End-of-instruction strobe, updates slave latch |
| pin_in | input | 8 | Pad input levels |
| af_out | input | 8 | Alternate-function output values |
| pad_do | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad output enable |
| pad_od | output | 8 | Pin operating as open-drain |
| pad_pu | output | 8 | Weak pull-up enable |

## Verification
Two pairs of events can fall in the same cycle. The first is a data-register write together with instr_end: the slave must take the older master value, and the new value must appear only at the next instr_end. The second is instr_start together with a read of address 0: the read must return the snapshot from before the edge, and the fresh sample must be visible one cycle later. Directed phases put each pair in one cycle on purpose. A long randomized phase then drives all strobes, writes and pad levels independently. A behavioural reference model in the bench judges the result by comparing every output on every cycle.

// File: rtl/gpio_stage_pkg.sv
package gpio_stage_pkg;
  typedef enum logic [1:0] {
    MODE_BIDIR = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN    = 2'b10,
    MODE_ALT   = 2'b11
  } pin_mode_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MLO  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MHI  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DSEL = 2'd3;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_stage_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  mode_lo,
  output logic [WIDTH-1:0]  mode_hi,
  output logic [WIDTH-1:0]  drv_sel,
  output logic [WIDTH-1:0]  master_q
);
  logic [WIDTH-1:0] mode_lo_d, mode_hi_d, drv_sel_d, master_d;
  logic             en_lo, en_hi, en_dsel, en_data;

  always_comb begin
    en_data   = bus_wr && (bus_addr == ADDR_DATA);
    en_lo     = bus_wr && (bus_addr == ADDR_MLO);
    en_hi     = bus_wr && (bus_addr == ADDR_MHI);
    en_dsel   = bus_wr && (bus_addr == ADDR_DSEL);
    master_d  = en_data ? bus_wdata : master_q;
    mode_lo_d = en_lo   ? bus_wdata : mode_lo;
    mode_hi_d = en_hi   ? bus_wdata : mode_hi;
    drv_sel_d = en_dsel ? bus_wdata : drv_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '1;
      mode_lo  <= '0;
      mode_hi  <= '0;
      drv_sel  <= '0;
    end else begin
      master_q <= master_d;
      mode_lo  <= mode_lo_d;
      mode_hi  <= mode_hi_d;
      drv_sel  <= drv_sel_d;
    end
  end

  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_MHI) |=> (mode_hi == $past(bus_wdata)));
endmodule

// File: rtl/gpio_stage_latch.sv
module gpio_stage_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_start,
  input  logic             instr_end,
  input  logic [WIDTH-1:0] master_q,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] slave_q,
  output logic [WIDTH-1:0] sample_q
);
  logic [WIDTH-1:0] slave_d, sample_d;

  always_comb begin
    slave_d  = instr_end   ? master_q : slave_q;
    sample_d = instr_start ? pin_in   : sample_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q  <= '1;
      sample_q <= '0;
    end else begin
      slave_q  <= slave_d;
      sample_q <= sample_d;
    end
  end

  assert_slave_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end |=> (slave_q == $past(master_q)));
  assert_slave_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end |=> $stable(slave_q));
  assert_sample_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_start |=> (sample_q == $past(pin_in)));
  assert_sample_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_start |=> $stable(sample_q));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_stage_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] mode_lo,
  input  logic [WIDTH-1:0] mode_hi,
  input  logic [WIDTH-1:0] drv_sel,
  input  logic [WIDTH-1:0] slave_q,
  input  logic [WIDTH-1:0] af_out,
  output logic [WIDTH-1:0] pad_do,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_od,
  output logic [WIDTH-1:0] pad_pu
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_mode_e mode;
    logic      src;
    logic      open_drain;

    always_comb begin
      mode       = pin_mode_e'({mode_hi[i], mode_lo[i]});
      src        = (mode == MODE_ALT) ? af_out[i] : slave_q[i];
      open_drain = (mode == MODE_BIDIR) || drv_sel[i];
      pad_pu[i]  = (mode == MODE_BIDIR);
      if (mode == MODE_IN) begin
        pad_oe[i] = 1'b0;
        pad_do[i] = 1'b0;
        pad_od[i] = 1'b0;
      end else if (open_drain) begin
        pad_oe[i] = ~src;
        pad_do[i] = 1'b0;
        pad_od[i] = 1'b1;
      end else begin
        pad_oe[i] = 1'b1;
        pad_do[i] = src;
        pad_od[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_stage_port.sv
module gpio_stage_port
  import gpio_stage_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              instr_start,
  input  logic              instr_end,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  af_out,
  output logic [WIDTH-1:0]  pad_do,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_od,
  output logic [WIDTH-1:0]  pad_pu
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] mode_lo, mode_hi, drv_sel, master_q, slave_q, sample_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode_lo(mode_lo), .mode_hi(mode_hi),
    .drv_sel(drv_sel), .master_q(master_q)
  );

  gpio_stage_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .instr_start(instr_start),
    .instr_end(instr_end), .master_q(master_q), .pin_in(pin_in),
    .slave_q(slave_q), .sample_q(sample_q)
  );

  gpio_pad_drive #(.WIDTH(WIDTH)) u_drive (
    .mode_lo(mode_lo), .mode_hi(mode_hi), .drv_sel(drv_sel),
    .slave_q(slave_q), .af_out(af_out), .pad_do(pad_do),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = sample_q;
      ADDR_MLO:  bus_rdata = mode_lo;
      ADDR_MHI:  bus_rdata = mode_hi;
      default:   bus_rdata = drv_sel;
    endcase
  end

  // Pull-up only where both mode bits are low.
  assert_pullup_bidir_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_pu & (mode_lo | mode_hi)) == '0);
  // Input-mode pins never enable the driver.
  assert_input_tristate_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_oe & mode_hi & ~mode_lo) == '0);
  // An open-drain pin never drives high.
  assert_od_no_high_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_oe & pad_od & pad_do) == '0);
endmodule

// File: tb/tb_gpio_stage_port.sv
`timescale 1ns/1ps
module tb_gpio_stage_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       instr_start = 1'b0;
  logic       instr_end = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] af_out = 8'h00;
  logic [7:0] pad_do, pad_oe, pad_od, pad_pu;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference state
  logic [7:0] m_master, m_slave, m_in, m_lo, m_hi, m_sel;

  always #2.5 clk = ~clk;

  gpio_stage_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .instr_start(instr_start),
    .instr_end(instr_end), .pin_in(pin_in), .af_out(af_out),
    .pad_do(pad_do), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_master = 8'hFF; m_slave = 8'hFF; m_in = 8'h00;
      m_lo = 8'h00; m_hi = 8'h00; m_sel = 8'h00;
    end else begin
      if (instr_end)   m_slave = m_master;
      if (instr_start) m_in = pin_in;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_master = bus_wdata;
          2'd1: m_lo = bus_wdata;
          2'd2: m_hi = bus_wdata;
          default: m_sel = bus_wdata;
        endcase
      end
    end
  end

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_do, e_oe, e_od, e_pu, e_rd;
    for (int i = 0; i < 8; i++) begin
      int  md = {m_hi[i], m_lo[i]};
      logic v;
      v = (md == 3) ? af_out[i] : m_slave[i];
      e_pu[i] = (md == 0);
      if (md == 2) begin
        e_oe[i] = 0; e_do[i] = 0; e_od[i] = 0;
      end else if (md == 0 || m_sel[i]) begin
        e_oe[i] = !v; e_do[i] = 0; e_od[i] = 1;
      end else begin
        e_oe[i] = 1; e_do[i] = v; e_od[i] = 0;
      end
    end
    case (bus_addr)
      2'd0: e_rd = m_in;
      2'd1: e_rd = m_lo;
      2'd2: e_rd = m_hi;
      default: e_rd = m_sel;
    endcase
    cmp("pad_oe", pad_oe, e_oe);
    cmp("pad_do", pad_do, e_do);
    cmp("pad_od", pad_od, e_od);
    cmp("pad_pu", pad_pu, e_pu);
    cmp("bus_rdata", bus_rdata, e_rd);
  endtask

  task automatic step(bit wr, logic [1:0] a, logic [7:0] wd, bit st, bit en,
                      logic [7:0] pin, logic [7:0] af);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    instr_start = st; instr_end = en; pin_in = pin; af_out = af;
    #1;
    compare_all();
  endtask

  task automatic idle(logic [1:0] a, int n);
    for (int k = 0; k < n; k++) step(0, a, 8'h00, 0, 0, pin_in, af_out);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, reads of all four registers
    cur_req = "R1";
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) idle(a[1:0], 1);

    // R3: write goes to master only, then strobe; write coinciding with strobe
    cur_req = "R3";
    step(1, 2'd0, 8'h5A, 0, 0, 8'h00, 8'h00);
    idle(2'd0, 3);
    step(0, 2'd0, 8'h00, 0, 1, 8'h00, 8'h00);
    idle(2'd0, 2);
    step(1, 2'd0, 8'hA5, 0, 1, 8'h00, 8'h00);
    idle(2'd0, 2);
    step(0, 2'd0, 8'h00, 0, 1, 8'h00, 8'h00);
    idle(2'd0, 2);

    // R4: pad change without strobe is invisible; strobe with read
    cur_req = "R4";
    step(0, 2'd0, 8'h00, 0, 0, 8'hC3, 8'h00);
    idle(2'd0, 2);
    step(0, 2'd0, 8'h00, 1, 0, 8'hC3, 8'h00);
    idle(2'd0, 1);
    step(0, 2'd0, 8'h00, 1, 1, 8'h96, 8'h00);
    idle(2'd0, 1);

    // R2: configuration write and readback
    cur_req = "R2";
    step(1, 2'd1, 8'h69, 0, 0, 8'h96, 8'h00); idle(2'd1, 1);
    step(1, 2'd2, 8'h3C, 0, 0, 8'h96, 8'h00); idle(2'd2, 1);
    step(1, 2'd3, 8'hE1, 0, 0, 8'h96, 8'h00); idle(2'd3, 1);

    // R5: all input, slave tracks master, then switch to push-pull output
    cur_req = "R5";
    step(1, 2'd3, 8'h00, 0, 0, 8'h96, 8'h00);
    step(1, 2'd1, 8'h00, 0, 0, 8'h96, 8'h00);
    step(1, 2'd2, 8'hFF, 0, 0, 8'h96, 8'h00);
    step(1, 2'd0, 8'h3C, 0, 0, 8'h96, 8'h00);
    step(0, 2'd0, 8'h00, 0, 1, 8'h96, 8'h00);
    idle(2'd0, 2);
    step(1, 2'd2, 8'h00, 0, 0, 8'h96, 8'h00);
    step(1, 2'd1, 8'hFF, 0, 0, 8'h96, 8'h00);
    idle(2'd0, 2);

    // R7: output mode, half push-pull, half open-drain
    cur_req = "R7";
    step(1, 2'd3, 8'hF0, 0, 0, 8'h96, 8'h00);
    idle(2'd0, 1);
    step(1, 2'd0, 8'h5A, 0, 1, 8'h96, 8'h00);
    step(0, 2'd0, 8'h00, 0, 1, 8'h96, 8'h00);
    idle(2'd0, 1);

    // R8: alternate function follows af_out
    cur_req = "R8";
    step(1, 2'd2, 8'hFF, 0, 0, 8'h96, 8'h0F);
    step(0, 2'd0, 8'h00, 0, 0, 8'h96, 8'hAA);
    step(0, 2'd0, 8'h00, 0, 0, 8'h96, 8'h55);

    // R6, R9: mixed modes per pin
    cur_req = "R6/R9";
    step(1, 2'd1, 8'h33, 0, 0, 8'h96, 8'h55);
    step(1, 2'd2, 8'h0F, 0, 0, 8'h96, 8'h55);
    step(1, 2'd0, 8'hC6, 0, 1, 8'h96, 8'h55);
    step(0, 2'd0, 8'h00, 0, 1, 8'h96, 8'h55);
    idle(2'd0, 2);

    // mixed random traffic exercising R2 to R9 together
    cur_req = "R3/R4 random";
    for (int k = 0; k < 2000; k++) begin
      step($urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)), 8'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           8'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule